// File: doc/BRIEF.md
# Reconfigurable Masked Binary Correlation Array

This block is a sliding correlator with 256 one-bit tap cells. Each valid input sample is shifted into the tap chain and compared against a stored reference pattern that holds one bit per tap. On every accepted sample the block produces one match count for each bit plane. A tap cell adds one to the count for its plane when its stored data bit equals the reference bit for its position and its mask bit is clear.

The cells are split into eight sections of 32. The sections chain together according to a sample-width setting, so that the same storage can hold longer streams of narrow samples or shorter streams of wide samples. Reference and mask bits are loaded eight at a time through a small write port into shadow copies. A transfer command moves both shadow copies into the active copies at once, on the edge of the next accepted sample, so the correlation that is running never sees a half-loaded pattern.

Top module: `bin_corr_array`

## Requirements
- R1: After reset `score_vld_o` is 0, every plane of `score_o` is 0, the width code is 0, and all reference, mask and tap bits are 0.
- R2: Width code c (register address 0, data bits [1:0]) selects W = 2^c bits per sample and a correlation length of L = 256/W taps. Plane b (b < W) holds sample bit b of the last L accepted samples in cells b*L .. b*L+L-1, with the newest sample at position 0.
- R3: Plane b's score counts the positions p < L where cell b*L+p equals active reference bit p and active mask bit b*L+p is 0. Reference bit p applies to the sample accepted p samples before the newest one.
- R4: Planes b >= W report 0. Sample bits at position W or higher are ignored.
- R5: The tap chain shifts only on clock edges where `sample_vld_i` is 1. The score for a sample is visible, with `score_vld_o` = 1, exactly two cycles after the cycle in which the sample was presented. In all other cycles `score_o` holds its value.
- R6: A write to address 1 stores data bit k into shadow reference bit 8n+k, where n is a 5-bit byte pointer. The pointer then increments and wraps from 31 to 0. A write to address 0 clears the pointer.
- R7: A write to address 2 stores data bit k into shadow mask bit 8m+k, where m is a separate 5-bit pointer with the same increment, wrap and clear behaviour. Mask bit i gates tap cell i.
- R8: Writes to the shadow reference or shadow mask do not change any score until a transfer takes place.
- R9: A write to address 3 arms a transfer. The transfer copies both shadow registers into the active registers on the next later clock edge where `sample_vld_i` is 1, and it stays armed through any idle cycles before that edge. The sample shifted on that edge is scored with the new values.
- R10: Writes to addresses 4 to 7 change neither the outputs nor any pointer or register.
- R11: A full match over 256 taps with width code 0 reports 256 on plane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Input sample; bit b feeds plane b |
| sample_vld_i | input | 1 | Marks `sample_i` as valid in this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 width code, 1 reference byte, 2 mask byte, 3 transfer |
| wr_data_i | input | 8 | Register write data |
| score_o | output | 72 | Eight 9-bit plane scores; plane b at bits [9b+8:9b] |
| score_vld_o | output | 1 | Marks a new score on `score_o` |

## Verification
The bench builds the block with its default parameters: eight sections of 32 taps and samples up to 8 bits wide. With these values all four width codes can be reached, the section chaining changes between every pair of modes, and a full 256-tap match can be driven to the top of the 9-bit score range. A behavioural model of lanes, shadow and active registers and the armed transfer is compared against both outputs on every clock. The bench covers idle gaps between samples, transfers held over those gaps, a pointer wrap, and writes to unused addresses.

// File: rtl/bc_pkg.sv
package bc_pkg;
  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_REF  = 3'd1,
    REG_MASK = 3'd2,
    REG_XFER = 3'd3
  } bc_reg_e;
endpackage

// File: rtl/bc_cfg_regs.sv
module bc_cfg_regs
  import bc_pkg::*;
#(
  parameter int TAPS    = 256,
  parameter int DW      = 8,
  parameter int WCODE_W = 2,
  localparam int NBYTES = TAPS / DW,
  localparam int PW     = $clog2(NBYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_vld_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  output logic [WCODE_W-1:0] width_o,
  output logic [TAPS-1:0]    ref_act_o,
  output logic [TAPS-1:0]    mask_act_o,
  output logic               xfer_pend_o,
  output logic [PW-1:0]      ref_ptr_o
);
  logic [TAPS-1:0]    ref_sh_q, mask_sh_q, ref_act_q, mask_act_q;
  logic [PW-1:0]      ref_ptr_q, mask_ptr_q;
  logic [WCODE_W-1:0] width_q;
  logic               pend_q;
  logic               xfer_wr;

  assign xfer_wr = wr_en_i && (wr_addr_i == REG_XFER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_sh_q   <= '0;
      mask_sh_q  <= '0;
      ref_act_q  <= '0;
      mask_act_q <= '0;
      ref_ptr_q  <= '0;
      mask_ptr_q <= '0;
      width_q    <= '0;
      pend_q     <= 1'b0;
    end else begin
      // swap lands on the edge that shifts the next valid sample
      if (pend_q && sample_vld_i) begin
        ref_act_q  <= ref_sh_q;
        mask_act_q <= mask_sh_q;
      end
      pend_q <= xfer_wr || (pend_q && !sample_vld_i);
      if (wr_en_i) begin
        case (wr_addr_i)
          REG_CFG: begin
            width_q    <= wr_data_i[WCODE_W-1:0];
            ref_ptr_q  <= '0;
            mask_ptr_q <= '0;
          end
          REG_REF: begin
            ref_sh_q[int'(ref_ptr_q)*DW +: DW] <= wr_data_i;
            ref_ptr_q <= ref_ptr_q + 1'b1;
          end
          REG_MASK: begin
            mask_sh_q[int'(mask_ptr_q)*DW +: DW] <= wr_data_i;
            mask_ptr_q <= mask_ptr_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign width_o     = width_q;
  assign ref_act_o   = ref_act_q;
  assign mask_act_o  = mask_act_q;
  assign xfer_pend_o = pend_q;
  assign ref_ptr_o   = ref_ptr_q;
endmodule

// File: rtl/bc_tap_section.sv
module bc_tap_section #(
  parameter int N     = 32,
  localparam int CW   = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          din_i,
  input  logic [N-1:0]  ref_i,
  input  logic [N-1:0]  mask_i,
  output logic          dout_o,
  output logic [CW-1:0] hits_o
);
  logic [N-1:0] cells_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cells_q <= '0;
    else if (shift_i) cells_q <= {cells_q[N-2:0], din_i};
  end

  always_comb begin
    hits_o = '0;
    for (int j = 0; j < N; j++)
      hits_o = hits_o + CW'(~mask_i[j] & ~(cells_q[j] ^ ref_i[j]));
  end

  assign dout_o = cells_q[N-1];
endmodule

// File: rtl/bc_plane_sum.sv
module bc_plane_sum #(
  parameter int NUM_SECT = 8,
  parameter int MAX_W    = 8,
  parameter int CW       = 6,
  parameter int SW       = 9,
  parameter int WCODE_W  = 2,
  localparam int SECT_LG = $clog2(NUM_SECT),
  localparam int LANE_W  = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
  input  logic [NUM_SECT-1:0][CW-1:0] sec_cnt_i,
  input  logic [WCODE_W-1:0]          code_i,
  output logic [MAX_W-1:0][SW-1:0]    plane_o
);
  // a section only feeds the plane of its lane; higher planes stay zero
  always_comb begin
    plane_o = '0;
    for (int s = 0; s < NUM_SECT; s++)
      plane_o[LANE_W'(SECT_LG'(s) >> (SECT_LG - int'(code_i)))] =
        plane_o[LANE_W'(SECT_LG'(s) >> (SECT_LG - int'(code_i)))] + SW'(sec_cnt_i[s]);
  end
endmodule

// File: rtl/bin_corr_array.sv
module bin_corr_array #(
  parameter int SECT_TAPS = 32,
  parameter int NUM_SECT  = 8,
  parameter int MAX_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [MAX_W-1:0]           sample_i,
  input  logic                       sample_vld_i,
  input  logic                       wr_en_i,
  input  logic [2:0]                 wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  output logic [MAX_W*$clog2(SECT_TAPS*NUM_SECT+1)-1:0] score_o,
  output logic                       score_vld_o
);
  localparam int TAPS    = SECT_TAPS * NUM_SECT;
  localparam int SECT_LG = $clog2(NUM_SECT);
  localparam int LOG_W   = $clog2(MAX_W);
  localparam int LANE_W  = (MAX_W > 1) ? LOG_W : 1;
  localparam int WCODE_W = (LOG_W > 0) ? $clog2(LOG_W + 1) : 1;
  localparam int SW      = $clog2(TAPS + 1);
  localparam int CW      = $clog2(SECT_TAPS + 1);
  localparam int TAP_IW  = $clog2(TAPS);
  localparam int PW      = $clog2(TAPS / 8);

  logic [WCODE_W-1:0]          width_q;
  logic [TAPS-1:0]             ref_act, mask_act, ref_cell;
  logic                        xfer_pend;
  logic [PW-1:0]               ref_ptr;
  logic [NUM_SECT-1:0]         sec_in, sec_out, sec_prev;
  logic [NUM_SECT-1:0][CW-1:0] sec_cnt;
  logic [MAX_W-1:0][SW-1:0]    plane, score_q;
  logic                        vld_q, score_vld_q;

  bc_cfg_regs #(.TAPS(TAPS), .DW(8), .WCODE_W(WCODE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_vld_i(sample_vld_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .width_o     (width_q),
    .ref_act_o   (ref_act),
    .mask_act_o  (mask_act),
    .xfer_pend_o (xfer_pend),
    .ref_ptr_o   (ref_ptr)
  );

  // reference is per lane position, shared by all planes
  always_comb begin
    for (int i = 0; i < TAPS; i++)
      ref_cell[i] = ref_act[TAP_IW'(i) & (TAP_IW'(TAPS - 1) >> width_q)];
  end

  assign sec_prev = {sec_out[NUM_SECT-2:0], 1'b0};

  // a section that starts a lane takes a sample bit, else chains on
  always_comb begin
    for (int s = 0; s < NUM_SECT; s++)
      sec_in[s] = ((SECT_LG'(s) & (SECT_LG'(NUM_SECT - 1) >> width_q)) == '0)
                ? sample_i[LANE_W'(SECT_LG'(s) >> (SECT_LG - int'(width_q)))]
                : sec_prev[s];
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    bc_tap_section #(.N(SECT_TAPS)) u_sect (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(sample_vld_i),
      .din_i  (sec_in[s]),
      .ref_i  (ref_cell[s*SECT_TAPS +: SECT_TAPS]),
      .mask_i (mask_act[s*SECT_TAPS +: SECT_TAPS]),
      .dout_o (sec_out[s]),
      .hits_o (sec_cnt[s])
    );
  end

  bc_plane_sum #(
    .NUM_SECT(NUM_SECT), .MAX_W(MAX_W), .CW(CW), .SW(SW), .WCODE_W(WCODE_W)
  ) u_sum (
    .sec_cnt_i(sec_cnt),
    .code_i   (width_q),
    .plane_o  (plane)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q       <= 1'b0;
      score_vld_q <= 1'b0;
      score_q     <= '0;
    end else begin
      vld_q       <= sample_vld_i;
      score_vld_q <= vld_q;
      if (vld_q) score_q <= plane;
    end
  end

  assign score_o     = score_q;
  assign score_vld_o = score_vld_q;
endmodule

// File: rtl/bin_corr_array_chk.sv
module bin_corr_array_chk
  import bc_pkg::*;
#(
  parameter int MAX_W   = 8,
  parameter int SW      = 9,
  parameter int TAPS    = 256,
  parameter int WCODE_W = 2,
  parameter int PW      = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sample_vld_i,
  input logic                  wr_en_i,
  input logic [2:0]            wr_addr_i,
  input logic [MAX_W*SW-1:0]   score_o,
  input logic                  score_vld_o,
  input logic [WCODE_W-1:0]    width_q,
  input logic                  xfer_pend,
  input logic [PW-1:0]         ref_ptr
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  a_r5_vld_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (score_vld_o == $past(sample_vld_i, 2)));

  a_r5_score_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !score_vld_o) |-> $stable(score_o));

  a_r9_xfer_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_XFER) |=> xfer_pend);

  a_r9_xfer_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_pend && sample_vld_i && !(wr_en_i && wr_addr_i == REG_XFER)) |=> !xfer_pend);

  a_r6_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == REG_CFG) |=> (ref_ptr == '0));

  for (genvar b = 0; b < MAX_W; b++) begin : g_plane
    a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q != 2'd0 && score_vld_o && (b >= (1 << $past(width_q))))
        |-> (score_o[b*SW +: SW] == '0));

    a_r11_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q != 2'd0 && score_vld_o)
        |-> (int'(score_o[b*SW +: SW]) <= (TAPS >> $past(width_q))));
  end
endmodule

bind bin_corr_array bin_corr_array_chk #(
  .MAX_W(MAX_W), .SW(SW), .TAPS(TAPS), .WCODE_W(WCODE_W), .PW(PW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_vld_i(sample_vld_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .score_o     (score_o),
  .score_vld_o (score_vld_o),
  .width_q     (width_q),
  .xfer_pend   (xfer_pend),
  .ref_ptr     (ref_ptr)
);

// File: tb/bin_corr_array_bench.sv
module bin_corr_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NT = 256;
  localparam int NW = 8;
  localparam int SW = 9;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NW-1:0]    sample_i = '0;
  logic             sample_vld_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [2:0]       wr_addr_i = '0;
  logic [7:0]       wr_data_i = '0;
  logic [NW*SW-1:0] score_o;
  logic             score_vld_o;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  bit m_cells[NT], m_ref_sh[NT], m_ref[NT], m_msk_sh[NT], m_msk[NT];
  int m_code = 0, m_rp = 0, m_mp = 0;
  bit m_pend = 0, m_vq = 0, m_sv = 0;
  int m_score[NW];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bin_corr_array u_bin_corr_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .sample_vld_i(sample_vld_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .score_o(score_o), .score_vld_o(score_vld_o)
  );

  task automatic model_edge(bit v, logic [NW-1:0] smp, bit we, logic [2:0] a, logic [7:0] d);
    int w, l, s;
    bit old[NT];
    w = 1 << m_code;
    l = NT / w;
    if (m_vq) begin
      for (int b = 0; b < NW; b++) begin
        s = 0;
        if (b < w)
          for (int p = 0; p < l; p++)
            if (m_cells[b*l+p] == m_ref[p] && !m_msk[b*l+p]) s++;
        m_score[b] = s;
      end
    end
    m_sv = m_vq;
    m_vq = v;
    if (m_pend && v) begin
      m_ref = m_ref_sh;
      m_msk = m_msk_sh;
    end
    m_pend = (we && a == 3'd3) || (m_pend && !v);
    if (v) begin
      old = m_cells;
      for (int b = 0; b < w; b++)
        for (int p = 0; p < l; p++)
          m_cells[b*l+p] = (p == 0) ? smp[b] : old[b*l+p-1];
    end
    if (we) begin
      case (a)
        3'd0: begin m_code = int'(d[1:0]); m_rp = 0; m_mp = 0; end
        3'd1: begin for (int k = 0; k < 8; k++) m_ref_sh[m_rp*8+k] = d[k]; m_rp = (m_rp + 1) % 32; end
        3'd2: begin for (int k = 0; k < 8; k++) m_msk_sh[m_mp*8+k] = d[k]; m_mp = (m_mp + 1) % 32; end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    logic [NW*SW-1:0] exp_s;
    for (int b = 0; b < NW; b++) exp_s[b*SW +: SW] = SW'(m_score[b]);
    checks++;
    if (score_vld_o !== m_sv || score_o !== exp_s) begin
      fails++;
      $display("FAIL %s: vld=%0b score=%h expected vld=%0b score=%h",
               cur_req, score_vld_o, score_o, m_sv, exp_s);
    end
  endtask

  task automatic cyc(bit v, logic [NW-1:0] smp, bit we, logic [2:0] a, logic [7:0] d);
    sample_vld_i = v; sample_i = smp; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    model_edge(v, smp, we, a, d);
    @(negedge clk_i);
    compare();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d); cyc(0, '0, 1, a, d); endtask
  task automatic smp(logic [NW-1:0] s); cyc(1, s, 0, 3'd0, 8'd0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, '0, 0, 3'd0, 8'd0); endtask
  task automatic stream(int n); for (int i = 0; i < n; i++) smp(NW'($urandom)); endtask
  task automatic load_ref_rand(); for (int n = 0; n < 32; n++) wr(3'd1, 8'($urandom)); endtask
  task automatic load_mask_rand(); for (int n = 0; n < 32; n++) wr(3'd2, 8'($urandom & $urandom)); endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) m_score[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    cur_req = "R1";
    compare();
    idle(2);

    // R6: reference load in width code 0, then R2/R3 main function
    cur_req = "R6";
    wr(3'd0, 8'h00);
    for (int n = 0; n < 32; n++) wr(3'd1, 8'((n * 73 + 17) & 255));
    for (int n = 0; n < 32; n++) wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    cur_req = "R2";
    stream(300);
    cur_req = "R3";
    load_ref_rand();
    wr(3'd3, 8'h00);
    stream(120);

    // R11: full-length match reaches 256
    cur_req = "R11";
    wr(3'd0, 8'h00);
    for (int n = 0; n < 32; n++) wr(3'd1, 8'hFF);
    for (int n = 0; n < 32; n++) wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    for (int i = 0; i < 260; i++) smp('1);
    idle(2);
    checks++;
    if (score_o[SW-1:0] !== 9'd256) begin
      fails++;
      $display("FAIL R11: plane0=%0d expected=256", score_o[SW-1:0]);
    end

    // R4: upper planes zero, upper sample bits ignored
    cur_req = "R4";
    wr(3'd0, 8'h03);
    load_ref_rand();
    load_mask_rand();
    wr(3'd3, 8'h00);
    stream(100);
    wr(3'd0, 8'h01);
    stream(150);
    wr(3'd0, 8'hFE);
    stream(100);

    // R7: mask gating in width code 2
    cur_req = "R7";
    wr(3'd0, 8'h02);
    load_mask_rand();
    wr(3'd3, 8'h00);
    stream(80);

    // R8: shadow writes without transfer
    cur_req = "R8";
    for (int n = 0; n < 32; n++) wr(3'd1, 8'($urandom));
    for (int n = 0; n < 32; n++) wr(3'd2, 8'h00);
    stream(50);

    // R9: armed transfer survives idle cycles
    cur_req = "R9";
    wr(3'd3, 8'h00);
    idle(5);
    stream(30);

    // R5: sparse valid
    cur_req = "R5";
    for (int i = 0; i < 200; i++) cyc(1'($urandom), NW'($urandom), 0, 3'd0, 8'd0);

    // R10: unused addresses
    cur_req = "R10";
    for (int a = 4; a < 8; a++) wr(3'(a), 8'($urandom));
    wr(3'd1, 8'hA5);
    wr(3'd3, 8'h00);
    stream(40);

    // R6: pointer wrap after 32 bytes
    cur_req = "R6";
    wr(3'd0, 8'h00);
    for (int n = 0; n < 33; n++) wr(3'd1, 8'($urandom));
    wr(3'd3, 8'h00);
    stream(300);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule